// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Switch

This block routes eight single-bit data lanes onto eight output lanes. Every output has its own 8:1 selector and its own enable, so any input may feed one output, several outputs or all of them at once. A disabled output drives 0 and lowers its enable bit, which a higher level can use to control a tri-state driver.

Routing is programmed in two steps. A load strobe writes an input number and a disable flag into the staging entry of one output, chosen by an output number. A separate commit strobe then moves every staging entry into the active bank that steers the selectors, all in the same clock edge. Traffic keeps flowing on the old routes while new ones are being staged. A reset strobe returns both banks to a known pattern: either every output carries input 0, or every output is off, depending on the disable flag at that moment. A chip select must be high for any of the three strobes to act. All strobes are level-sensitive and are sampled on the rising edge of the system clock.

Top module: `xpt_switch_top`

## Requirements
- R1: While output o is enabled, dout[o] equals din[s], where s is the source in the active entry of o; dout follows din with no register in between.
- R2: in_sel and out_sel are unsigned binary numbers with bit 2 as the most significant bit: in_sel = 3'b110 names input 6 and out_sel = 3'b001 names output 1.
- R3: On each rising edge where cs and load_stb are high (and rst_stb is not), the staging entry of output out_sel takes {dis, in_sel}. Other staging entries, the active bank and all outputs stay unchanged.
- R4: On each rising edge where cs and cfg_stb are high (and rst_stb is not), every active entry takes the staging value it held before that edge. With cfg_stb low, the active bank holds its value.
- R5: An output whose active disable bit is 1 has dout_en = 0 and dout = 0. Staging and committing a disable flag of 0 for that output enables it again.
- R6: An edge with cs and rst_stb high and dis low sets every staging and active entry to source 0, enabled, so that every output carries din[0].
- R7: An edge with cs and rst_stb high and dis high sets every staging and active entry to source 0, disabled, so that every dout_en and every dout is 0.
- R8: While cs is low, rst_stb, load_stb and cfg_stb have no effect on either bank.
- R9: When rst_stb is applied in the same edge as load_stb or cfg_stb, the reset result wins.
- R10: While rst_n is low, both banks are held in the R6 pattern.
- R11: A commit leaves every output whose staged entry equals its active entry unchanged in that edge.
- R12: When load_stb and cfg_stb are high in the same edge, the commit copies the staging bank as it was before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs | input | 1 | Chip select that qualifies all strobes, active high |
| rst_stb | input | 1 | Reset strobe for both banks |
| load_stb | input | 1 | Staging write strobe |
| cfg_stb | input | 1 | Commit strobe (staging to active) |
| in_sel | input | 3 | Source input number to stage |
| out_sel | input | 3 | Output whose staging entry is written |
| dis | input | 1 | Disable flag for load, reset-mode select for reset |
| din | input | 8 | Input data lanes |
| dout | output | 8 | Output data lanes, 0 when disabled |
| dout_en | output | 8 | Per-output enable |

## Verification
A corrupted active entry shows at the ports at once: the wrong lane, or a lane stuck at 0 with its enable low, appears on dout right after the edge that stored it. A corrupted staging entry stays hidden until the next commit, so after each commit the bench applies six din patterns that together give every input a unique code, and any wrong source number shows up within that one cycle. Gating by chip select and the ordering of reset against load and commit are checked at the edges where they collide.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Meaning of the dis input when it is sampled with the reset strobe.
    typedef enum logic {
        XPT_RST_BCAST = 1'b0,
        XPT_RST_OFF   = 1'b1
    } xpt_rst_mode_e;

    function automatic xpt_rst_mode_e xpt_mode_of(input logic dis_flag);
        return dis_flag ? XPT_RST_OFF : XPT_RST_BCAST;
    endfunction

endpackage

// File: rtl/xpt_strobe_gate.sv
module xpt_strobe_gate (
    input  logic cs,
    input  logic rst_stb,
    input  logic load_stb,
    input  logic cfg_stb,
    output logic rst_hit,
    output logic ld_en,
    output logic cp_en
);
    // Reset outranks load and commit in the same edge.
    always_comb begin
        rst_hit = cs & rst_stb;
        ld_en   = cs & load_stb & ~rst_stb;
        cp_en   = cs & cfg_stb & ~rst_stb;
    end
endmodule

// File: rtl/xpt_stage_bank.sv
module xpt_stage_bank
    import xpt_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int SEL_W = 3,
    parameter int OSEL_W = $clog2(N_OUT)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rst_hit,
    input  xpt_rst_mode_e                 rst_mode,
    input  logic                          wr_en,
    input  logic [OSEL_W-1:0]             wr_idx,
    input  logic [SEL_W-1:0]              wr_src,
    input  logic                          wr_off,
    output logic [N_OUT-1:0][SEL_W-1:0]   stg_src,
    output logic [N_OUT-1:0]              stg_off
);
    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] src;
        logic [N_OUT-1:0]            off;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_hit) begin
            st_d.src = '0;
            st_d.off = {N_OUT{rst_mode == XPT_RST_OFF}};
        end else if (wr_en) begin
            for (int o = 0; o < N_OUT; o++) begin
                if (wr_idx == OSEL_W'(o)) begin
                    st_d.src[o] = wr_src;
                    st_d.off[o] = wr_off;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stg_src = st_q.src;
    assign stg_off = st_q.off;

    p_load_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rst_hit) |=> (stg_src[$past(wr_idx)] == $past(wr_src))
                                && (stg_off[$past(wr_idx)] == $past(wr_off)));

    p_stage_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rst_hit) |=> ($stable(stg_src) && $stable(stg_off)));

    p_stage_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_hit && rst_mode == XPT_RST_BCAST) |=> (stg_src == '0 && stg_off == '0));
endmodule

// File: rtl/xpt_active_bank.sv
module xpt_active_bank
    import xpt_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int SEL_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rst_hit,
    input  xpt_rst_mode_e                 rst_mode,
    input  logic                          cp_en,
    input  logic [N_OUT-1:0][SEL_W-1:0]   stg_src,
    input  logic [N_OUT-1:0]              stg_off,
    output logic [N_OUT-1:0][SEL_W-1:0]   act_src,
    output logic [N_OUT-1:0]              act_off
);
    typedef struct packed {
        logic [N_OUT-1:0][SEL_W-1:0] src;
        logic [N_OUT-1:0]            off;
    } active_t;

    active_t ac_d, ac_q;

    always_comb begin
        ac_d = ac_q;
        if (rst_hit) begin
            ac_d.src = '0;
            ac_d.off = {N_OUT{rst_mode == XPT_RST_OFF}};
        end else if (cp_en) begin
            ac_d.src = stg_src;
            ac_d.off = stg_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign act_src = ac_q.src;
    assign act_off = ac_q.off;

    p_commit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_en && !rst_hit) |=> (act_src == $past(stg_src) && act_off == $past(stg_off)));

    p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_en && !rst_hit) |=> ($stable(act_src) && $stable(act_off)));

    p_reset_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_hit && rst_mode == XPT_RST_OFF) |=> (act_off == '1 && act_src == '0));

    for (genvar o = 0; o < N_OUT; o++) begin : g_keep
        p_unchanged_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (cp_en && !rst_hit && stg_src[o] == act_src[o] && stg_off[o] == act_off[o])
                |=> ($stable(act_src[o]) && $stable(act_off[o])));
    end
endmodule

// File: rtl/xpt_out_sel.sv
module xpt_out_sel #(
    parameter int N_IN  = 8,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  din,
    input  logic [SEL_W-1:0] src,
    input  logic             off,
    output logic             dout,
    output logic             dout_en
);
    always_comb begin
        dout_en = ~off;
        dout    = 1'b0;
        if (!off && (int'(src) < N_IN)) dout = din[src];
    end
endmodule

// File: rtl/xpt_switch_top.sv
module xpt_switch_top
    import xpt_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 8,
    localparam int SEL_W  = $clog2(N_IN),
    localparam int OSEL_W = $clog2(N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rst_stb,
    input  logic              load_stb,
    input  logic              cfg_stb,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [OSEL_W-1:0] out_sel,
    input  logic              dis,
    input  logic [N_IN-1:0]   din,
    output logic [N_OUT-1:0]  dout,
    output logic [N_OUT-1:0]  dout_en
);
    logic rst_hit, ld_en, cp_en;
    xpt_rst_mode_e rst_mode;
    logic [N_OUT-1:0][SEL_W-1:0] stg_src, act_src;
    logic [N_OUT-1:0]            stg_off, act_off;

    assign rst_mode = xpt_mode_of(dis);

    xpt_strobe_gate u_gate (
        .cs       (cs),
        .rst_stb  (rst_stb),
        .load_stb (load_stb),
        .cfg_stb  (cfg_stb),
        .rst_hit  (rst_hit),
        .ld_en    (ld_en),
        .cp_en    (cp_en)
    );

    xpt_stage_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W), .OSEL_W(OSEL_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_hit  (rst_hit),
        .rst_mode (rst_mode),
        .wr_en    (ld_en),
        .wr_idx   (out_sel),
        .wr_src   (in_sel),
        .wr_off   (dis),
        .stg_src  (stg_src),
        .stg_off  (stg_off)
    );

    xpt_active_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_hit  (rst_hit),
        .rst_mode (rst_mode),
        .cp_en    (cp_en),
        .stg_src  (stg_src),
        .stg_off  (stg_off),
        .act_src  (act_src),
        .act_off  (act_off)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        xpt_out_sel #(.N_IN(N_IN), .SEL_W(SEL_W)) u_sel (
            .din     (din),
            .src     (act_src[o]),
            .off     (act_off[o]),
            .dout    (dout[o]),
            .dout_en (dout_en[o])
        );
    end

    p_cs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(dout_en) && $stable(act_src)));

    p_bcast_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rst_stb && !dis) |=> (dout_en == '1 && dout == {N_OUT{din[0]}}));

    p_off_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rst_stb && dis) |=> (dout_en == '0 && dout == '0));

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout & ~dout_en) == '0));
endmodule

// File: tb/xpt_switch_top_tb_top.sv
`timescale 1ns/1ps
module xpt_switch_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rst_stb = 1'b0, load_stb = 1'b0, cfg_stb = 1'b0, dis = 1'b0;
    logic [2:0] in_sel = '0, out_sel = '0;
    logic [7:0] din = '0;
    logic [7:0] dout, dout_en;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_ssrc [8];
    bit m_soff [8];
    int m_asrc [8];
    bit m_aoff [8];

    always #4 clk = ~clk;

    xpt_switch_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rst_stb(rst_stb), .load_stb(load_stb),
        .cfg_stb(cfg_stb), .in_sel(in_sel), .out_sel(out_sel), .dis(dis),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic model_reset(input bit off);
        for (int o = 0; o < 8; o++) begin
            m_ssrc[o] = 0; m_soff[o] = off;
            m_asrc[o] = 0; m_aoff[o] = off;
        end
    endtask

    // Apply strobes for exactly one rising edge and update the model (R3, R4, R6..R9, R12).
    task automatic cycle(input bit c, input bit r, input bit l, input bit g,
                         input int o, input int i, input bit d);
        @(negedge clk);
        cs = c; rst_stb = r; load_stb = l; cfg_stb = g;
        out_sel = 3'(o); in_sel = 3'(i); dis = d;
        @(posedge clk);
        if (c && r) model_reset(d);
        else begin
            if (c && g) for (int k = 0; k < 8; k++) begin
                m_asrc[k] = m_ssrc[k]; m_aoff[k] = m_soff[k];
            end
            if (c && l) begin m_ssrc[o] = i; m_soff[o] = d; end
        end
        #1;
        cs = 0; rst_stb = 0; load_stb = 0; cfg_stb = 0;
    endtask

    // Six din patterns give each input a distinct code (R1, R2, R5).
    task automatic check_all(input string tag);
        logic [7:0] exp_d, exp_e;
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 8; i++)
                din[i] = (p < 3) ? 1'((i >> p) & 1) : 1'(~((i >> (p - 3)) & 1));
            #0.5;
            for (int o = 0; o < 8; o++) begin
                exp_e[o] = ~m_aoff[o];
                exp_d[o] = m_aoff[o] ? 1'b0 : din[m_asrc[o]];
            end
            tests++;
            if (dout !== exp_d || dout_en !== exp_e) begin
                fails++;
                $display("FAIL %s: dout=%h dout_en=%h expected dout=%h dout_en=%h",
                         tag, dout, dout_en, exp_d, exp_e);
            end
        end
    endtask

    task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        logic [31:0] lf;
        logic [7:0]  keep;
        model_reset(1'b0);
        #20;
        // R10: held in broadcast pattern during rst_n
        din = 8'h01; #1;
        expect8("R10 reset enables", dout_en, 8'hFF);
        expect8("R10 reset routes input 0", dout, 8'hFF);
        @(negedge clk); rst_n = 1'b1;
        check_all("R10 after release");

        // R1/R2/R3/R4: every input to every output; staged but uncommitted change not visible
        for (int o = 0; o < 8; o++) begin
            for (int i = 0; i < 8; i++) begin
                cycle(1, 0, 1, 0, o, i, 0);
                check_all("R3 staged not visible");
                cycle(1, 0, 0, 1, 0, 0, 0);
                check_all("R1 R2 routed after commit");
            end
        end

        // R4: all eight staged in background, one commit
        for (int o = 0; o < 8; o++) cycle(1, 0, 1, 0, o, (o * 5 + 3) % 8, 0);
        check_all("R4 holds before commit");
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R4 all committed");

        // R5: disable then re-enable
        cycle(1, 0, 1, 0, 3, 6, 1);
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R5 disabled lane");
        expect8("R5 lane 3 enable low", dout_en & 8'h08, 8'h00);
        cycle(1, 0, 1, 0, 3, 6, 0);
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R5 re-enabled lane");

        // R11: unchanged lanes keep value across commit
        din = 8'b1011_0010;
        cycle(1, 0, 1, 0, 5, 0, 0);
        #0.5 keep = dout;
        cycle(1, 0, 0, 1, 0, 0, 0);
        #0.5;
        expect8("R11 unchanged lanes stable", dout & 8'hDF, keep & 8'hDF);
        check_all("R11 after commit");

        // R7 then R6
        cycle(1, 1, 0, 0, 0, 0, 1);
        check_all("R7 all disabled");
        expect8("R7 enables low", dout_en, 8'h00);
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R7 staging also cleared");
        cycle(1, 1, 0, 0, 0, 0, 0);
        check_all("R6 broadcast");
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R6 staging also broadcast");

        // R8: chip select low blocks everything
        cycle(1, 0, 1, 0, 2, 7, 0);
        cycle(0, 1, 1, 1, 2, 4, 1);
        check_all("R8 cs low ignored");
        cycle(0, 0, 0, 1, 0, 0, 0);
        check_all("R8 commit with cs low ignored");
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R8 staging untouched by cs-low load");

        // R9: reset wins over load and commit
        cycle(1, 0, 1, 0, 1, 5, 0);
        cycle(1, 1, 1, 1, 1, 5, 1);
        check_all("R9 reset priority");
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R9 staging reset, load dropped");

        // R12: load and commit in same edge
        cycle(1, 0, 1, 0, 0, 4, 0);
        cycle(1, 0, 1, 1, 0, 6, 0);
        check_all("R12 commit takes pre-load staging");
        cycle(1, 0, 0, 1, 0, 0, 0);
        check_all("R12 later commit takes new entry");

        // Pseudo-random mix (R3 R4 R8)
        lf = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            cycle(lf[0] | lf[1], lf[7:2] == 6'd0, lf[8], lf[9] & lf[10],
                  int'(lf[13:11]), int'(lf[16:14]), lf[17] & lf[18]);
            check_all("R4 random sequence");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule